// File: doc/BRIEF.md
# Weighted Random Early Drop Admission with Drop Precedence

This block decides whether a packet arriving at a transmit queue is accepted or discarded. The caller presents the queue's current occupancy in packets, a flag saying whether the packet may be dropped first, and either a profile index or a request to use a fixed tail-drop limit. One clock later the block returns a registered admit or drop decision.

Each profile holds four occupancy thresholds. The start and ceiling thresholds of the protected class apply to packets without the flag. The start and ceiling thresholds of the yielding class apply to flagged packets. A profile also holds a ceiling drop probability in percent. How the four thresholds relate to each other gives the behaviour:

- All four equal gives plain tail drop.
- Start equal to ceiling in each class, with different values per class, gives tail drop with precedence.
- Ceiling above start, with both classes equal, gives random early drop.
- Ceiling above start in both classes, with the classes differing, gives random early drop with precedence.

Between start and ceiling, the drop chance rises linearly. A 16-bit linear feedback shift register supplies the random value for each decision.

Top module: `wred_admit`

## Requirements
- R1: After reset, `dec_valid` and `cfg_err` are 0. Every profile holds 1023 in all four thresholds and 0 as its ceiling probability, so with a profile selected a packet is admitted exactly when occupancy is below 1023.
- R2: When `req_prof_en` is 0, the profile is ignored. The packet is admitted exactly when `req_occ < req_fixed_thr`.
- R3: With a profile selected, a packet whose occupancy is below its class's start threshold is always admitted.
- R4: With a profile selected, a packet whose occupancy is at or above its class's ceiling threshold is always dropped.
- R5: `req_drop_elig` = 1 selects the yielding class thresholds (`lo_*`). `req_drop_elig` = 0 selects the protected class thresholds (`hi_*`).
- R6: For occupancy o with start ≤ o < ceiling, the drop chance is maxp·(o−start)/(ceiling−start) percent. With a ceiling probability of 0, no packet in that range is dropped. At o equal to start, no packet is dropped.
- R7: The random value is a 16-bit Galois LFSR with tap mask 0xB400 and seed 0xACE1. It advances once per decision and is never zero. A packet is dropped when r·100·(ceiling−start) < maxp·(o−start)·65536. With a ceiling of 100 percent at mid-range, about half of the packets are dropped.
- R8: A profile write is accepted only if all of these hold: hi_max ≥ hi_min, lo_max ≥ lo_min, hi_max ≥ lo_max and hi_min ≥ lo_min. A rejected write leaves the profile unchanged and pulses `cfg_err` high in the next cycle. An accepted write leaves `cfg_err` low.
- R9: A profile write with a ceiling probability above 100 is rejected in the same way.
- R10: `dec_valid` is high in the cycle after `req_valid` is high and low otherwise. `dec_admit` is registered with it.
- R11: When a write and a decision name the same profile in the same cycle, the decision uses the profile contents from before the write. The next decision uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Profile write strobe |
| cfg_prof | input | 2 | Profile index to write |
| cfg_hi_min | input | 10 | Protected class start threshold |
| cfg_hi_max | input | 10 | Protected class ceiling threshold |
| cfg_lo_min | input | 10 | Yielding class start threshold |
| cfg_lo_max | input | 10 | Yielding class ceiling threshold |
| cfg_maxp | input | 7 | Ceiling drop probability, percent |
| cfg_err | output | 1 | One-cycle pulse for a rejected write |
| req_valid | input | 1 | Decision request |
| req_occ | input | 10 | Queue occupancy in packets |
| req_drop_elig | input | 1 | Packet belongs to the yielding class |
| req_prof_en | input | 1 | 1: use profile, 0: use fixed limit |
| req_prof | input | 2 | Profile index to use |
| req_fixed_thr | input | 10 | Fixed tail-drop limit |
| dec_valid | output | 1 | Decision valid |
| dec_admit | output | 1 | 1 admit, 0 drop |

## Verification
A profile write and a decision that reads the same profile can land in the same clock edge. The bench drives both in one cycle on a profile whose old and new thresholds give opposite outcomes at the chosen occupancy. It then expects the old outcome, and the new outcome from the decision that follows. Rejected writes are judged the same way, by observing a decision whose outcome would flip had the write landed.

// File: rtl/wred_pkg.sv
package wred_pkg;
  parameter int OCC_W    = 10;
  parameter int PCT_W    = 7;
  parameter int PCT_FULL = 100;

  typedef struct packed {
    logic [OCC_W-1:0] hi_min;
    logic [OCC_W-1:0] hi_max;
    logic [OCC_W-1:0] lo_min;
    logic [OCC_W-1:0] lo_max;
    logic [PCT_W-1:0] maxp;
  } prof_t;

  localparam prof_t PROF_RST = '{hi_min: '1, hi_max: '1, lo_min: '1, lo_max: '1, maxp: '0};

  function automatic logic prof_ok(prof_t p);
    return (p.hi_max >= p.hi_min) && (p.lo_max >= p.lo_min) &&
           (p.hi_max >= p.lo_max) && (p.hi_min >= p.lo_min) &&
           (int'(p.maxp) <= PCT_FULL);
  endfunction
endpackage

// File: rtl/wred_prof_rf.sv
module wred_prof_rf
  import wred_pkg::*;
#(
  parameter int NUM_PROF = 4,
  parameter int PSEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PSEL_W-1:0] wr_idx,
  input  prof_t             wr_data,
  input  logic [PSEL_W-1:0] rd_idx,
  output prof_t             rd_data,
  output logic              wr_err
);
  prof_t prof_q [NUM_PROF];
  logic  wr_ok;
  logic  err_d, err_q;

  always_comb begin
    wr_ok = prof_ok(wr_data);
    err_d = wr_en && !wr_ok;
  end

  for (genvar g = 0; g < NUM_PROF; g++) begin : g_prof
    logic load;
    always_comb load = wr_en && wr_ok && (wr_idx == PSEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prof_q[g] <= PROF_RST;
      else if (load) prof_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  always_comb begin
    rd_data = prof_q[rd_idx];
    wr_err  = err_q;
  end
endmodule

// File: rtl/wred_lfsr.sv
module wred_lfsr #(
  parameter int               LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS  = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [LFSR_W-1:0] value
);
  logic [LFSR_W-1:0] st_q, st_d;

  always_comb begin
    st_d = (st_q >> 1) ^ (st_q[0] ? TAPS : '0);
    value = st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= SEED;
    else if (adv) st_q <= st_d;
  end
endmodule

// File: rtl/wred_decide.sv
module wred_decide
  import wred_pkg::*;
#(
  parameter int LFSR_W = 16
) (
  input  logic [OCC_W-1:0]  occ,
  input  logic              drop_elig,
  input  logic              prof_en,
  input  logic [OCC_W-1:0]  fixed_thr,
  input  prof_t             prof,
  input  logic [LFSR_W-1:0] rnd,
  output logic              admit,
  output logic [OCC_W-1:0]  sel_max
);
  localparam int PROD_W = LFSR_W + PCT_W + OCC_W;

  logic [OCC_W-1:0]  sel_min, span, diff;
  logic [PROD_W-1:0] lhs, rhs;
  logic              rnd_drop;

  always_comb begin
    sel_min  = drop_elig ? prof.lo_min : prof.hi_min;
    sel_max  = drop_elig ? prof.lo_max : prof.hi_max;
    span     = sel_max - sel_min;
    diff     = occ - sel_min;
    lhs      = PROD_W'(rnd) * PROD_W'(PCT_FULL) * PROD_W'(span);
    rhs      = (PROD_W'(prof.maxp) * PROD_W'(diff)) << LFSR_W;
    rnd_drop = lhs < rhs;
    if (!prof_en)           admit = occ < fixed_thr;
    else if (occ < sel_min) admit = 1'b1;
    else if (occ >= sel_max) admit = 1'b0;
    else                    admit = !rnd_drop;
  end
endmodule

// File: rtl/wred_admit.sv
module wred_admit
  import wred_pkg::*;
#(
  parameter int NUM_PROF = 4,
  parameter int LFSR_W   = 16,
  localparam int PSEL_W  = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PSEL_W-1:0] cfg_prof,
  input  logic [OCC_W-1:0]  cfg_hi_min,
  input  logic [OCC_W-1:0]  cfg_hi_max,
  input  logic [OCC_W-1:0]  cfg_lo_min,
  input  logic [OCC_W-1:0]  cfg_lo_max,
  input  logic [PCT_W-1:0]  cfg_maxp,
  output logic              cfg_err,
  input  logic              req_valid,
  input  logic [OCC_W-1:0]  req_occ,
  input  logic              req_drop_elig,
  input  logic              req_prof_en,
  input  logic [PSEL_W-1:0] req_prof,
  input  logic [OCC_W-1:0]  req_fixed_thr,
  output logic              dec_valid,
  output logic              dec_admit
);
  prof_t             wr_prof, rd_prof;
  logic [LFSR_W-1:0] lfsr_val;
  logic [OCC_W-1:0]  sel_max;
  logic              admit_c;
  logic              vld_d, vld_q, adm_d, adm_q;

  always_comb begin
    wr_prof.hi_min = cfg_hi_min;
    wr_prof.hi_max = cfg_hi_max;
    wr_prof.lo_min = cfg_lo_min;
    wr_prof.lo_max = cfg_lo_max;
    wr_prof.maxp   = cfg_maxp;
  end

  wred_prof_rf #(.NUM_PROF(NUM_PROF), .PSEL_W(PSEL_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_prof),
    .wr_data(wr_prof), .rd_idx(req_prof), .rd_data(rd_prof), .wr_err(cfg_err)
  );

  wred_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(req_valid), .value(lfsr_val)
  );

  wred_decide #(.LFSR_W(LFSR_W)) u_dec (
    .occ(req_occ), .drop_elig(req_drop_elig), .prof_en(req_prof_en),
    .fixed_thr(req_fixed_thr), .prof(rd_prof), .rnd(lfsr_val),
    .admit(admit_c), .sel_max(sel_max)
  );

  always_comb begin
    vld_d = req_valid;
    adm_d = req_valid && admit_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      adm_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      adm_q <= adm_d;
    end
  end

  always_comb begin
    dec_valid = vld_q;
    dec_admit = adm_q;
  end
endmodule

// File: rtl/wred_admit_chk.sv
module wred_admit_chk
  import wred_pkg::*;
#(
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [OCC_W-1:0]  cfg_hi_min,
  input logic [OCC_W-1:0]  cfg_hi_max,
  input logic              cfg_err,
  input logic              req_valid,
  input logic              req_prof_en,
  input logic [OCC_W-1:0]  req_occ,
  input logic [OCC_W-1:0]  req_fixed_thr,
  input logic [OCC_W-1:0]  sel_max,
  input logic [LFSR_W-1:0] lfsr_val,
  input logic              dec_valid,
  input logic              dec_admit
);
  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid);
  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dec_valid);
  // R2
  fixed_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_prof_en) |=> (dec_admit == ($past(req_occ) < $past(req_fixed_thr))));
  // R4
  above_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_prof_en && req_occ >= sel_max) |=> !dec_admit);
  // R8
  bad_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_hi_max < cfg_hi_min) |=> cfg_err);
  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we));
  // R7
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_val != '0);
endmodule

bind wred_admit wred_admit_chk #(.LFSR_W(LFSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hi_min(cfg_hi_min),
  .cfg_hi_max(cfg_hi_max), .cfg_err(cfg_err), .req_valid(req_valid),
  .req_prof_en(req_prof_en), .req_occ(req_occ), .req_fixed_thr(req_fixed_thr),
  .sel_max(sel_max), .lfsr_val(lfsr_val), .dec_valid(dec_valid),
  .dec_admit(dec_admit)
);

// File: tb/wred_admit_bench.sv
module wred_admit_bench;
  localparam time CLK_P = 20ns;

  logic       clk, rst_n;
  logic       cfg_we;
  logic [1:0] cfg_prof;
  logic [9:0] cfg_hi_min, cfg_hi_max, cfg_lo_min, cfg_lo_max;
  logic [6:0] cfg_maxp;
  logic       cfg_err;
  logic       req_valid, req_drop_elig, req_prof_en;
  logic [9:0] req_occ, req_fixed_thr;
  logic [1:0] req_prof;
  logic       dec_valid, dec_admit;

  int n_run, n_fail;
  bit finished;

  wred_admit u_wred_admit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_prof(cfg_prof),
    .cfg_hi_min(cfg_hi_min), .cfg_hi_max(cfg_hi_max), .cfg_lo_min(cfg_lo_min),
    .cfg_lo_max(cfg_lo_max), .cfg_maxp(cfg_maxp), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_occ(req_occ), .req_drop_elig(req_drop_elig),
    .req_prof_en(req_prof_en), .req_prof(req_prof), .req_fixed_thr(req_fixed_thr),
    .dec_valid(dec_valid), .dec_admit(dec_admit)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] p, input int hmin, input int hmax,
                         input int lmin, input int lmax, input int mp);
    cfg_prof = p; cfg_hi_min = 10'(hmin); cfg_hi_max = 10'(hmax);
    cfg_lo_min = 10'(lmin); cfg_lo_max = 10'(lmax); cfg_maxp = 7'(mp);
  endtask

  task automatic set_req(input int occ, input bit de, input bit en,
                         input logic [1:0] p, input int thr);
    req_occ = 10'(occ); req_drop_elig = de; req_prof_en = en;
    req_prof = p; req_fixed_thr = 10'(thr);
  endtask

  task automatic cfg_write(input logic [1:0] p, input int hmin, input int hmax,
                           input int lmin, input int lmax, input int mp, output bit err);
    @(negedge clk);
    set_cfg(p, hmin, hmax, lmin, lmax, mp);
    cfg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    err = cfg_err;
  endtask

  task automatic decide(input int occ, input bit de, input bit en,
                        input logic [1:0] p, input int thr, output bit adm, output bit vld);
    @(negedge clk);
    set_req(occ, de, en, p, thr);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    adm = dec_admit;
    vld = dec_valid;
  endtask

  task automatic t_reset();
    bit a, v;
    chk(dec_valid == 1'b0, "R1 dec_valid after reset", dec_valid, 0);
    chk(cfg_err == 1'b0, "R1 cfg_err after reset", cfg_err, 0);
    decide(1022, 1'b0, 1'b1, 2'd3, 0, a, v);
    chk(a == 1'b1, "R1 default profile occ 1022", a, 1);
    decide(1023, 1'b1, 1'b1, 2'd3, 0, a, v);
    chk(a == 1'b0, "R1 default profile occ 1023", a, 0);
  endtask

  task automatic t_latency();
    bit a, v;
    decide(5, 1'b0, 1'b0, 2'd0, 10, a, v);
    chk(v == 1'b1, "R10 dec_valid one cycle after request", v, 1);
    @(negedge clk);
    chk(dec_valid == 1'b0, "R10 dec_valid drops when idle", dec_valid, 0);
  endtask

  task automatic t_fixed();
    bit a, v;
    decide(49, 1'b1, 1'b0, 2'd3, 50, a, v);
    chk(a == 1'b1, "R2 fixed limit below", a, 1);
    decide(50, 1'b0, 1'b0, 2'd3, 50, a, v);
    chk(a == 1'b0, "R2 fixed limit at", a, 0);
    decide(0, 1'b0, 1'b0, 2'd3, 0, a, v);
    chk(a == 1'b0, "R2 fixed limit zero", a, 0);
  endtask

  task automatic t_tail_prec();
    bit a, v, e;
    cfg_write(2'd0, 600, 600, 300, 300, 0, e);
    chk(e == 1'b0, "R8 valid write accepted", e, 0);
    decide(299, 1'b1, 1'b1, 2'd0, 0, a, v);
    chk(a == 1'b1, "R3 yielding class below start", a, 1);
    decide(300, 1'b1, 1'b1, 2'd0, 0, a, v);
    chk(a == 1'b0, "R4 yielding class at ceiling", a, 0);
    decide(400, 1'b0, 1'b1, 2'd0, 0, a, v);
    chk(a == 1'b1, "R5 protected class at 400", a, 1);
    decide(400, 1'b1, 1'b1, 2'd0, 0, a, v);
    chk(a == 1'b0, "R5 yielding class at 400", a, 0);
    decide(600, 1'b0, 1'b1, 2'd0, 0, a, v);
    chk(a == 1'b0, "R4 protected class at ceiling", a, 0);
  endtask

  task automatic t_red();
    bit a, v, e;
    int drops;
    cfg_write(2'd1, 100, 500, 100, 500, 0, e);
    drops = 0;
    for (int i = 0; i < 50; i++) begin
      decide(100 + i * 8, i[0], 1'b1, 2'd1, 0, a, v);
      if (!a) drops++;
    end
    chk(drops == 0, "R6 zero ceiling probability", drops, 0);
    cfg_write(2'd1, 100, 500, 100, 500, 100, e);
    drops = 0;
    for (int i = 0; i < 50; i++) begin
      decide(100, 1'b0, 1'b1, 2'd1, 0, a, v);
      if (!a) drops++;
    end
    chk(drops == 0, "R6 occupancy at start", drops, 0);
    drops = 0;
    for (int i = 0; i < 200; i++) begin
      decide(300, 1'b0, 1'b1, 2'd1, 0, a, v);
      if (!a) drops++;
    end
    chk(drops >= 60 && drops <= 140, "R7 mid-range about half dropped", drops, 100);
    drops = 0;
    for (int i = 0; i < 200; i++) begin
      decide(450, 1'b1, 1'b1, 2'd1, 0, a, v);
      if (!a) drops++;
    end
    chk(drops >= 145 && drops < 200, "R7 high range mostly dropped", drops, 175);
    decide(500, 1'b0, 1'b1, 2'd1, 0, a, v);
    chk(a == 1'b0, "R4 RED at ceiling", a, 0);
  endtask

  task automatic t_reject();
    bit a, v, e;
    cfg_write(2'd0, 700, 600, 300, 300, 0, e);
    chk(e == 1'b1, "R8 start above ceiling rejected", e, 1);
    decide(650, 1'b0, 1'b1, 2'd0, 0, a, v);
    chk(a == 1'b0, "R8 profile kept after reject", a, 0);
    cfg_write(2'd0, 600, 600, 300, 650, 0, e);
    chk(e == 1'b1, "R8 yielding ceiling above protected rejected", e, 1);
    decide(400, 1'b1, 1'b1, 2'd0, 0, a, v);
    chk(a == 1'b0, "R8 profile kept after second reject", a, 0);
    cfg_write(2'd0, 700, 700, 300, 300, 101, e);
    chk(e == 1'b1, "R9 probability 101 rejected", e, 1);
    decide(650, 1'b0, 1'b1, 2'd0, 0, a, v);
    chk(a == 1'b0, "R9 profile kept after reject", a, 0);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R8 error is a single pulse", cfg_err, 0);
  endtask

  task automatic t_same_cycle();
    bit a, v, e;
    cfg_write(2'd2, 100, 100, 100, 100, 0, e);
    @(negedge clk);
    set_cfg(2'd2, 900, 900, 900, 900, 0);
    set_req(500, 1'b0, 1'b1, 2'd2, 0);
    cfg_we = 1'b1;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b0;
    chk(dec_admit == 1'b0, "R11 same-cycle decision uses old profile", dec_admit, 0);
    decide(500, 1'b0, 1'b1, 2'd2, 0, a, v);
    chk(a == 1'b1, "R11 next decision uses new profile", a, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    n_run = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; req_valid = 1'b0;
    set_cfg(2'd0, 0, 0, 0, 0, 0);
    set_req(0, 1'b0, 1'b0, 2'd0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_fixed();
    t_tail_prec();
    t_red();
    t_reject();
    t_same_cycle();
    finish_run();
  end
endmodule